// File: doc/BRIEF.md
# Audio RAM Time-Slot Scheduler

This block shares one 16-bit sound-sample RAM among the consumers of a fixed-length sample period. Each period is a whole number of equal-length RAM accesses. The block walks through the voices in ascending order. Every voice slot is three accesses long: two reads on behalf of that voice, then one access set aside for host data. The voice decoder supplies the read address for the access in progress. The scheduler tells it which voice and which fetch is being served.

Host or DMA logic pushes 16-bit words into a small staging buffer. They do not reach RAM as a burst. Instead, each voice slot's host access writes at most one word, the oldest one in the buffer, to an address that advances by one after every write. Software loads that address beforehand. When the buffer has nothing in it, the host access stays idle. The accesses left over after the last voice slot are reserved and issue no strobe. The block raises a buffer-empty flag so the feeder knows when the next chunk may be sent.

With the defaults, a period is 96 accesses of 8 cycles, which is 768 cycles. That gives 44.1 kHz from a 33.8688 MHz clock. There are 24 voices and a 32-word buffer, so the buffer drains at one word every 32 cycles on average.

Top module: `aram_slot_sched`

## Requirements
- R1: A sample period lasts ACCESSES_PER_PERIOD × ACCESS_CYCLES clock cycles. After the last cycle, the schedule restarts with voice 0, fetch 0.
- R2: Every access lasts ACCESS_CYCLES cycles. A RAM strobe (`ram_rd` or `ram_wr`) is high only in the first cycle of an access, and for that one cycle only.
- R3: Voice slots run in ascending voice order, and each slot is three accesses. Access 0 is a read with `cur_fetch`=0. Access 1 is a read with `cur_fetch`=1. Access 2 is the host transfer. During a read, `ram_addr` equals `voice_addr`, and `ram_rd` and `ram_wr` are never high together.
- R4: At a host-transfer access, if the buffer holds data, `ram_wr` pulses with `ram_wdata` set to the oldest staged word. That word then leaves the buffer.
- R5: At a host-transfer access with an empty buffer, no strobe is issued.
- R6: Accesses after the last voice slot are reserved: `voice_active` is 0 and no strobe is issued.
- R7: The staging buffer keeps BUF_DEPTH words in arrival order. A push arriving while the buffer is full is dropped, even if a word leaves in that same cycle.
- R8: `host_addr_load` sets the write address to `host_addr`. Each host write then advances it by one, wrapping modulo 2^ADDR_W. If a load and a write fall in the same cycle, the load wins.
- R9: `buf_empty` is 1 exactly when no word is staged. It rises in the cycle after the write of the last staged word.
- R10: After reset, the buffer is empty, the write address is 0 and the schedule sits at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_valid | input | 1 | Push one word into the staging buffer this cycle |
| host_wr_data | input | DATA_W | Word to push |
| host_addr_load | input | 1 | Load the transfer write address |
| host_addr | input | ADDR_W | Value for the transfer write address |
| voice_addr | input | ADDR_W | Read address from the voice decoder for the current voice and fetch |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address for the current strobe |
| ram_wdata | output | DATA_W | RAM write data |
| cur_voice | output | VOICE_W | Voice whose slot is in progress |
| cur_fetch | output | 1 | Which of the voice's two reads is in progress |
| voice_active | output | 1 | High during voice slots, low in the reserved tail |
| buf_empty | output | 1 | Staging buffer holds no word |

## Verification
The bench builds the block with 2-cycle accesses, 3 voices, a 12-access period (so 3 reserved accesses) and a 4-word buffer with an 8-bit address. At these sizes a period is only 24 cycles, so many period wraps and reserved tails fall inside a short run. A six-word back-to-back push is certain to overrun the buffer, because at most one word can drain during the push. A write address loaded near the top of its range wraps after a few writes. The bench keeps its own model of slot position, buffer fill and write address, and checks every strobe, address and data word against it.

// File: rtl/aram_pkg.sv
package aram_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH0 = 2'd0,
        ACC_FETCH1 = 2'd1,
        ACC_XFER   = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/aram_slot_timer.sv
module aram_slot_timer
    import aram_pkg::*;
#(
    parameter int ACCESS_CYCLES       = 8,
    parameter int NUM_VOICES          = 24,
    parameter int ACCESSES_PER_PERIOD = 96,
    localparam int PHASE_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1,
    localparam int ACC_W   = $clog2(ACCESSES_PER_PERIOD),
    localparam int VOICE_W = $clog2(NUM_VOICES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               access_start,
    output logic               period_start,
    output logic               voice_active,
    output logic [VOICE_W-1:0] voice,
    output acc_kind_e          kind
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [ACC_W-1:0]   acc;
        logic [VOICE_W-1:0] voice;
        acc_kind_e          kind;
    } tmr_t;

    tmr_t st_q, st_d;

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(ACCESS_CYCLES - 1);
    localparam logic [ACC_W-1:0]   LAST_ACC   = ACC_W'(ACCESSES_PER_PERIOD - 1);
    localparam logic [VOICE_W-1:0] NV         = VOICE_W'(NUM_VOICES);

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST_PHASE) begin
            st_d.phase = '0;
            if (st_q.acc == LAST_ACC) begin
                st_d.acc   = '0;
                st_d.voice = '0;
                st_d.kind  = ACC_FETCH0;
            end else begin
                st_d.acc = st_q.acc + 1'b1;
                if (st_q.voice < NV) begin
                    case (st_q.kind)
                        ACC_FETCH0: st_d.kind = ACC_FETCH1;
                        ACC_FETCH1: st_d.kind = ACC_XFER;
                        default: begin
                            st_d.kind  = ACC_FETCH0;
                            st_d.voice = st_q.voice + 1'b1;
                        end
                    endcase
                end
            end
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: '0, acc: '0, voice: '0, kind: ACC_FETCH0};
        end else begin
            st_q <= st_d;
        end
    end

    assign access_start = (st_q.phase == '0);
    assign period_start = access_start && (st_q.acc == '0);
    assign voice_active = (st_q.voice < NV);
    assign voice        = st_q.voice;
    assign kind         = st_q.kind;
endmodule

// File: rtl/aram_stage_fifo.sv
module aram_stage_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] count;
    } fifo_t;

    fifo_t st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.count != FULL_CNT);
        do_pop  = pop && (st_q.count != '0);
        st_d    = st_q;
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign head  = mem_q[st_q.rd_ptr];
    assign empty = (st_q.count == '0);
    assign full  = (st_q.count == FULL_CNT);
endmodule

// File: rtl/aram_xfer_addr.sv
module aram_xfer_addr #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q, addr_d;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/aram_slot_sched.sv
module aram_slot_sched
    import aram_pkg::*;
#(
    parameter int ACCESS_CYCLES       = 8,
    parameter int NUM_VOICES          = 24,
    parameter int ACCESSES_PER_PERIOD = 96,
    parameter int BUF_DEPTH           = 32,
    parameter int DATA_W              = 16,
    parameter int ADDR_W              = 18,
    localparam int VOICE_W = $clog2(NUM_VOICES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_valid,
    input  logic [DATA_W-1:0]  host_wr_data,
    input  logic               host_addr_load,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [ADDR_W-1:0]  voice_addr,
    output logic               ram_rd,
    output logic               ram_wr,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    output logic [VOICE_W-1:0] cur_voice,
    output logic               cur_fetch,
    output logic               voice_active,
    output logic               buf_empty
);
    logic              access_start;
    logic              period_start;
    acc_kind_e         kind;
    logic [DATA_W-1:0] head;
    logic              buf_full;
    logic [ADDR_W-1:0] xfer_addr;
    logic              xfer_slot;

    aram_slot_timer #(
        .ACCESS_CYCLES      (ACCESS_CYCLES),
        .NUM_VOICES         (NUM_VOICES),
        .ACCESSES_PER_PERIOD(ACCESSES_PER_PERIOD)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .access_start(access_start),
        .period_start(period_start),
        .voice_active(voice_active),
        .voice       (cur_voice),
        .kind        (kind)
    );

    aram_stage_fifo #(
        .DEPTH (BUF_DEPTH),
        .DATA_W(DATA_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (host_wr_valid),
        .push_data(host_wr_data),
        .pop      (ram_wr),
        .head     (head),
        .empty    (buf_empty),
        .full     (buf_full)
    );

    aram_xfer_addr #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (host_addr_load),
        .load_val(host_addr),
        .step    (ram_wr),
        .addr    (xfer_addr)
    );

    always_comb begin
        xfer_slot = access_start && voice_active && (kind == ACC_XFER);
        ram_rd    = access_start && voice_active && (kind != ACC_XFER);
        ram_wr    = xfer_slot && !buf_empty;
        ram_addr  = ram_wr ? xfer_addr : voice_addr;
        ram_wdata = head;
        cur_fetch = (kind == ACC_FETCH1);
    end
endmodule

// File: rtl/aram_slot_sched_chk.sv
module aram_slot_sched_chk #(
    parameter int ACCESS_CYCLES       = 8,
    parameter int ACCESSES_PER_PERIOD = 96,
    parameter int ADDR_W              = 18,
    parameter int VOICE_W             = 5,
    localparam int PERIOD = ACCESS_CYCLES * ACCESSES_PER_PERIOD,
    localparam int CNT_W  = $clog2(PERIOD + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ram_rd,
    input logic               ram_wr,
    input logic               buf_empty,
    input logic               host_addr_load,
    input logic [ADDR_W-1:0]  xfer_addr,
    input logic [VOICE_W-1:0] cur_voice,
    input logic               voice_active,
    input logic               period_start
);
    logic [CNT_W-1:0] cyc_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cyc_q  <= period_start ? '0 : cyc_q + 1'b1;
            seen_q <= seen_q | period_start;
        end
    end

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && period_start |-> cyc_q == CNT_W'(PERIOD - 1)); // R1
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_wr) |=> !(ram_rd || ram_wr)); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr)); // R3
    AST_VOICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        voice_active && $past(voice_active) && (cur_voice != $past(cur_voice))
        |-> cur_voice == VOICE_W'($past(cur_voice) + 1'b1)); // R3
    AST_WR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> !buf_empty); // R5
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !voice_active |-> !(ram_rd || ram_wr)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ram_wr) && !$past(host_addr_load)
        |-> xfer_addr == ADDR_W'($past(xfer_addr) + 1'b1)); // R8
endmodule

bind aram_slot_sched aram_slot_sched_chk #(
    .ACCESS_CYCLES      (ACCESS_CYCLES),
    .ACCESSES_PER_PERIOD(ACCESSES_PER_PERIOD),
    .ADDR_W             (ADDR_W),
    .VOICE_W            (VOICE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ram_rd        (ram_rd),
    .ram_wr        (ram_wr),
    .buf_empty     (buf_empty),
    .host_addr_load(host_addr_load),
    .xfer_addr     (xfer_addr),
    .cur_voice     (cur_voice),
    .voice_active  (voice_active),
    .period_start  (period_start)
);

// File: tb/aram_slot_sched_tb_top.sv
module aram_slot_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AC  = 2;
    localparam int NV  = 3;
    localparam int APP = 12;
    localparam int DEP = 4;
    localparam int DW  = 16;
    localparam int AW  = 8;
    localparam int PER = AC * APP;
    localparam int VW  = $clog2(NV + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_valid = 1'b0;
    logic [DW-1:0] host_wr_data = '0;
    logic          host_addr_load = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [AW-1:0] voice_addr;
    logic          ram_rd, ram_wr, cur_fetch, voice_active, buf_empty;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [VW-1:0] cur_voice;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign voice_addr = AW'(8'h80 + {cur_voice, cur_fetch});

    aram_slot_sched #(
        .ACCESS_CYCLES(AC), .NUM_VOICES(NV), .ACCESSES_PER_PERIOD(APP),
        .BUF_DEPTH(DEP), .DATA_W(DW), .ADDR_W(AW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
        .host_addr_load(host_addr_load), .host_addr(host_addr),
        .voice_addr(voice_addr),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cur_voice(cur_voice), .cur_fetch(cur_fetch),
        .voice_active(voice_active), .buf_empty(buf_empty)
    );

    int checks = 0;
    int fails  = 0;
    int drops  = 0;
    int writes_seen = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q [$];
    int            k = 0;
    int            mcnt = 0;
    logic [AW-1:0] maddr = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_wr_at(input int kk, input int cnt);
        int s = kk % PER;
        int a = s / AC;
        return (s % AC == 0) && (a < 3 * NV) && (a % 3 == 2) && (cnt > 0);
    endfunction

    // Reference model of buffer fill and write address, advanced at each edge
    always @(posedge clk) begin
        if (rst_n) begin
            bit pop;
            bit push;
            pop  = exp_wr_at(k, mcnt);
            push = host_wr_valid && (mcnt < DEP);
            mcnt = mcnt + int'(push) - int'(pop);
            if (host_addr_load) maddr = host_addr;
            else if (pop) maddr = maddr + 1'b1;
            k = k + 1;
        end
    end

    // Monitor: compares outputs mid-cycle against the schedule and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                int s, a, v, kd;
                bit va, erd, ewr;
                s   = k % PER;
                a   = s / AC;
                va  = a < 3 * NV;
                v   = a / 3;
                kd  = a % 3;
                erd = (s % AC == 0) && va && (kd != 2);
                ewr = exp_wr_at(k, mcnt);
                chk(voice_active == va, "R6 voice_active", voice_active, va);
                chk(ram_rd == erd, va ? "R3 ram_rd" : "R6 ram_rd", ram_rd, erd);
                chk(ram_wr == ewr, (mcnt > 0) ? "R4 ram_wr" : "R5 ram_wr", ram_wr, ewr);
                if (erd) begin
                    chk(ram_addr == AW'(8'h80 + v * 2 + kd), "R3 read address",
                        ram_addr, 8'h80 + v * 2 + kd);
                    if (s == 0 && k >= PER)
                        chk(ram_addr == 8'h80, "R1 restart at voice 0", ram_addr, 8'h80);
                end
                if (ram_wr) begin
                    writes_seen++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected write", ram_wdata, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        chk(ram_wdata == e, "R7 write data order", ram_wdata, e);
                    end
                    chk(ram_addr == maddr, "R8 write address", ram_addr, maddr);
                end
                chk(buf_empty == (mcnt == 0), "R9 buf_empty", buf_empty, mcnt == 0);
            end
        end
    end

    task automatic host_push(input logic [DW-1:0] d);
        @(negedge clk);
        host_wr_valid = 1'b1;
        host_wr_data  = d;
        if (mcnt < DEP) exp_q.push_back(d);
        else drops++;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic host_push_burst(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_wr_valid = 1'b1;
            host_wr_data  = base + DW'(i);
            if (mcnt < DEP) exp_q.push_back(base + DW'(i));
            else drops++;
        end
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        @(negedge clk);
        host_addr_load = 1'b1;
        host_addr      = a;
        @(negedge clk);
        host_addr_load = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(buf_empty == 1'b1, "R10 empty in reset", buf_empty, 1);
        chk(ram_wr == 1'b0, "R10 no write in reset", ram_wr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // idle periods: empty transfer slots stay quiet (R5), reserved tail (R6)
        repeat (2 * PER) @(negedge clk);
        // R4 / R8: first writes go to address 0 after reset
        host_push(16'hA001);
        host_push(16'hA002);
        host_push(16'hA003);
        repeat (3 * PER) @(negedge clk);
        chk(writes_seen == 3, "R4 three words drained", writes_seen, 3);
        chk(maddr == 8'd3, "R10 address started at 0", maddr, 3);
        // R7 overrun and R8 wrap near the top of the address range
        load_addr(8'hFE);
        host_push_burst(6, 16'hB000);
        chk(drops > 0, "R7 push dropped when full", drops, 1);
        repeat (4 * PER) @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        chk(maddr < 8'hFE, "R8 address wrapped", maddr, 3);
        // R9: empty after last word; single pushes spread across slots
        load_addr(8'h40);
        for (int i = 0; i < 5; i++) begin
            host_push(16'hC000 + DW'(i));
            repeat (i + 3) @(negedge clk);
        end
        repeat (3 * PER) @(negedge clk);
        chk(buf_empty == 1'b1, "R9 empty at end", buf_empty, 1);
        chk(writes_seen >= 12, "R4 total writes", writes_seen, 12);
        finish_run();
    end
endmodule